// File: doc/BRIEF.md
# Segmented Microprogram Memory Loader

This block sits in front of a wide microprogram store and lets a maintenance controller fill it, read it back and move to a chosen word, 16 bits at a time. Each stored word is 80 bits wide and is reached as five 16-bit slices through one combined word-address and slice-index counter. The store itself is modelled inside the block as a plain register file.

The controller issues four commands: home the counter, seek a word, write one slice and read one slice. Slices are visited top slice first. Every write or read steps the counter onward, so a whole block of words can be streamed without re-addressing. The seek command advances the word address once per clock until it equals a target. It then parks on the top slice of that word. A select input gates all activity, and a one-clock write strobe with its data is brought out for observation.

Top module: `seg_ucode_loader`

## Requirements
- R1: The slice index runs from 4 (the most significant 16 bits of a word) down to 0 (the least significant 16 bits). Commands are coded on `cmd_op` as 0 = home, 1 = seek, 2 = write slice, 3 = read slice.
- R2: A home command sets the word address to 0 and the slice index to 4, visible in the cycle after the command.
- R3: Each accepted write or read moves the slice index down by one. From slice 0 it returns to slice 4 and the word address goes up by one.
- R4: After slice 0 of the last word, the counter wraps to word 0, slice 4.
- R5: A seek command raises `busy` in the next cycle and captures the low address bits of `in_lo` as the target. In each busy cycle the word address either matches the target or goes up by one with wrap. `busy` is therefore high for (target − start) mod WORDS + 1 cycles.
- R6: When the seek ends, `busy` falls, the word address equals the target and the slice index is 4, even if the seek started mid-word.
- R7: A write stores `in_lo` into the current slice. A read places the current slice in `out_reg[15:0]` with `out_reg[31:16]` zero, visible in the cycle after the command.
- R8: `we_o` is high for exactly the cycle after each accepted write, with `wr_data` holding the value written. It is low at all other times.
- R9: While `sel` is low, commands are ignored and a running seek pauses. The address, slice, output register and store keep their values.
- R10: Commands that arrive while `busy` is high are ignored. They produce no write strobe and leave the output register unchanged.
- R11: After reset the word address is 0, the slice index is 4, and `busy`, `we_o` and `out_reg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Enables this store's responses |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (R1) |
| in_lo | input | SEG_W | Write data and seek target |
| out_reg | output | 2*SEG_W | Read-back register |
| wr_data | output | SEG_W | Data of the last write |
| we_o | output | 1 | One-clock write strobe |
| word_addr | output | AW | Current word address |
| seg_idx | output | SW | Current slice index |
| busy | output | 1 | Seek in progress |

## Verification
The bench runs a configuration with 8 words. It writes every slice of every word with a value computed from its position, then reads all of them back. Errors in slice order, rollover or wrap show up as mismatched data or counter values. Seeks are run for every start and target pair, each starting on a mid-word slice. The busy length tells an off-by-one apart from a wrong wrap, and the final slice shows whether the park on the top slice happened. Separate patterns drop `sel` during a seek, issue a write with `sel` low, and issue a write while busy, to confirm that nothing moves.

// File: rtl/seg_ucode_loader.sv
module seg_ucode_loader #(
  parameter int WORDS = 1024,
  parameter int SEGS  = 5,
  parameter int SEG_W = 16,
  localparam int AW     = $clog2(WORDS),
  localparam int SW     = $clog2(SEGS),
  localparam int WORD_W = SEGS * SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEG_W-1:0]  in_lo,
  output logic [2*SEG_W-1:0] out_reg,
  output logic [SEG_W-1:0]  wr_data,
  output logic              we_o,
  output logic [AW-1:0]     word_addr,
  output logic [SW-1:0]     seg_idx,
  output logic              busy
);

  localparam logic [1:0] OP_HOME = 2'd0, OP_SEEK = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;
  localparam logic [SW-1:0] TOP = SW'(SEGS - 1);

  logic [WORD_W-1:0] store [WORDS];
  logic [AW-1:0]     target;

  wire go        = sel && cmd_valid && !busy;
  wire access    = go && (cmd_op == OP_WR || cmd_op == OP_RD);
  wire last_word = word_addr == AW'(WORDS - 1);
  wire [AW-1:0] addr_inc = last_word ? '0 : word_addr + 1'b1;
  wire hit       = word_addr == target;
  wire [SEG_W-1:0] seg_rd = store[word_addr][int'(seg_idx)*SEG_W +: SEG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr <= '0;
      seg_idx   <= TOP;
      busy      <= 1'b0;
      target    <= '0;
      we_o      <= 1'b0;
      wr_data   <= '0;
      out_reg   <= '0;
    end else begin
      we_o <= 1'b0;
      if (sel && busy) begin
        if (hit) begin
          busy    <= 1'b0;
          seg_idx <= TOP;
        end else begin
          word_addr <= addr_inc;
        end
      end else if (go) begin
        case (cmd_op)
          OP_HOME: begin
            word_addr <= '0;
            seg_idx   <= TOP;
          end
          OP_SEEK: begin
            busy   <= 1'b1;
            target <= in_lo[AW-1:0];
          end
          OP_WR: begin
            we_o    <= 1'b1;
            wr_data <= in_lo;
          end
          default: out_reg <= {{SEG_W{1'b0}}, seg_rd};
        endcase
        if (access) begin
          if (seg_idx == '0) begin
            seg_idx   <= TOP;
            word_addr <= addr_inc;
          end else begin
            seg_idx <= seg_idx - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && cmd_op == OP_WR)
      store[word_addr][int'(seg_idx)*SEG_W +: SEG_W] <= in_lo;
  end

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= TOP); // R1

  AST_HOME_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_HOME) |=> (word_addr == '0 && seg_idx == TOP)); // R2

  AST_SEEK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && busy && !hit) |=>
      (word_addr == (($past(word_addr) == AW'(WORDS - 1)) ? AW'(0) : AW'($past(word_addr) + 1'b1)))); // R5

  AST_SEEK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (word_addr == target && seg_idx == TOP)); // R6

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> $past(sel && cmd_valid && !busy && cmd_op == OP_WR)); // R8

  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(word_addr) && $stable(seg_idx) && $stable(out_reg) && !we_o)); // R9

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (!we_o && $stable(out_reg))); // R10

endmodule

// File: tb/tb_seg_ucode_loader.sv
module tb_seg_ucode_loader;
  localparam int WORDS = 8, SEGS = 5, SEG_W = 16;
  localparam int AW = $clog2(WORDS), SW = $clog2(SEGS);

  logic clk = 0, rst_n = 0, sel = 1, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [SEG_W-1:0] in_lo = 0;
  logic [2*SEG_W-1:0] out_reg;
  logic [SEG_W-1:0] wr_data;
  logic we_o, busy;
  logic [AW-1:0] word_addr;
  logic [SW-1:0] seg_idx;

  int checks = 0, fails = 0;

  seg_ucode_loader #(.WORDS(WORDS), .SEGS(SEGS), .SEG_W(SEG_W)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .in_lo(in_lo), .out_reg(out_reg), .wr_data(wr_data), .we_o(we_o),
    .word_addr(word_addr), .seg_idx(seg_idx), .busy(busy));

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [SEG_W-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; in_lo = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] pat(int a, int s);
    return 16'h5000 + 16'(a * 16) + 16'(s) + 16'(a * s * 256);
  endfunction

  initial begin
    int n;
    repeat (2) @(negedge clk);
    check("R11 addr", word_addr, 0);
    check("R11 seg", seg_idx, 4);
    check("R11 busy", busy, 0);
    check("R11 we", we_o, 0);
    check("R11 out", out_reg, 0);
    rst_n = 1;

    for (int a = 0; a < WORDS; a++)
      for (int s = 4; s >= 0; s--) begin
        check("R3 addr before write", word_addr, a);
        check("R1 R3 seg before write", seg_idx, s);
        issue(2, pat(a, s));
        check("R8 we", we_o, 1);
        check("R8 wr_data", wr_data, pat(a, s));
        @(negedge clk);
        check("R8 we one clock", we_o, 0);
      end
    check("R4 wrap addr", word_addr, 0);
    check("R4 wrap seg", seg_idx, 4);

    for (int a = 0; a < WORDS; a++)
      for (int s = 4; s >= 0; s--) begin
        issue(3, 0);
        check("R7 read data", out_reg, {16'h0, pat(a, s)});
        check("R8 no strobe on read", we_o, 0);
      end
    check("R4 wrap after reads", {word_addr, seg_idx} == {AW'(0), SW'(4)}, 1);

    for (int s = 0; s < WORDS; s++)
      for (int t = 0; t < WORDS; t++) begin
        issue(0, 0);
        check("R2 home", {word_addr, seg_idx} == {AW'(0), SW'(4)}, 1);
        if (s != 0) begin
          issue(1, 16'(s));
          wait_idle(n);
        end
        issue(3, 0);
        issue(1, 16'(t));
        check("R5 busy raised", busy, 1);
        wait_idle(n);
        check("R5 busy length", n, ((t - s + WORDS) % WORDS) + 1);
        check("R6 parked addr", word_addr, t);
        check("R6 parked seg", seg_idx, 4);
      end

    issue(0, 0);
    issue(1, 16'd6);
    sel = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 seek paused addr", word_addr, 0);
      check("R9 seek paused busy", busy, 1);
    end
    sel = 1;
    wait_idle(n);
    check("R9 seek resumed", word_addr, 6);

    issue(0, 0);
    issue(3, 0);
    issue(0, 0);
    sel = 0;
    issue(2, 16'hDEAD);
    check("R9 no strobe deselected", we_o, 0);
    check("R9 addr held", word_addr, 0);
    check("R9 seg held", seg_idx, 4);
    issue(3, 0);
    check("R9 out held", out_reg, {16'h0, pat(0, 4)});
    sel = 1;
    issue(2, 16'h0000);
    issue(0, 0);
    issue(3, 0);
    check("R7 slice rewritten", out_reg, 0);
    issue(3, 0);
    check("R9 store untouched", out_reg, {16'h0, pat(0, 3)});

    issue(0, 0);
    issue(1, 16'd5);
    issue(2, 16'hBEEF);
    check("R10 no strobe while busy", we_o, 0);
    issue(3, 0);
    check("R10 out unchanged while busy", out_reg, {16'h0, pat(0, 3)});
    wait_idle(n);
    check("R10 seek unaffected", word_addr, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule